// File: doc/BRIEF.md
# Token-Passing Column Readout Arbiter

This block shares one column bus among a chain of pixel regions. A small controller watches the ORed request of all regions. When any region has a packet waiting, the controller sends a single one-cycle token into the first region of a daisy chain and then waits. A region that holds the token and still has packets puts one packet on the bus in each cycle, acknowledging each one to its source. When the region has nothing left, it hands the token to its neighbour. A region with nothing to send passes the token on in one cycle.

When the token leaves the last region it goes back to the controller. If any region is still requesting at that point, the controller starts a new pass at once. Otherwise it goes back to idle. Only one token exists at a time, so exactly one region can own the bus. Service within a pass follows the chain order, from region 0 upward. A region that raises a request after the token has passed it waits for the next pass.

Top module: `col_token_arbiter`

## Requirements
- R1: During reset and in the first cycle after it, `token_launch`, `bus_valid`, `reg_ack` and `bus_data` are all 0.
- R2: While the controller is idle and every bit of `reg_req` is 0, `token_launch` stays 0.
- R3: When the idle controller sees any `reg_req` bit at 1 on a clock edge, `token_launch` is 1 for exactly the one following cycle.
- R4: The token is held by region 0 in the cycle after the launch cycle. A region whose request is 0 when it holds the token passes the token to the next region in one cycle.
- R5: A region i that holds the token with `reg_req[i]`=1 asserts `reg_ack[i]`, `bus_valid`=1 and `bus_data` = `reg_data[i*DATA_W +: DATA_W]`, for one packet per cycle. It keeps the token for as long as `reg_req[i]` stays 1.
- R6: At most one bit of `reg_ack` is 1 in any cycle, and `bus_valid` is 1 exactly when some bit of `reg_ack` is 1.
- R7: In the cycle in which the token leaves the last region, the controller checks the requests. If any request is set, it launches again in the next cycle. If none is set, it goes idle.
- R8: No new token is launched while a token is still in the chain. A request that appears in a region ahead of the token is served in the same pass, with no extra launch.
- R9: `bus_data` is 0 in every cycle in which `bus_valid` is 0.
- R10: Within one pass, regions are served in ascending index order. Region i starts sending in cycle L+1+i+(sum of the packets sent by regions below i), where L is the launch cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_req | input | NUM_REG | Per-region packet-pending flag |
| reg_data | input | NUM_REG*DATA_W | Per-region packet, region i at bits i*DATA_W +: DATA_W |
| reg_ack | output | NUM_REG | Per-region packet taken in this cycle |
| bus_valid | output | 1 | Column bus carries a packet |
| bus_data | output | DATA_W | Column bus packet, 0 when idle |
| token_launch | output | 1 | One-cycle token sent into region 0 |

## Verification
The chain and the controller have one register stage each. A request that becomes visible before an edge therefore causes a launch in the cycle after that edge. Region 0 holds the token one cycle after the launch. Each empty region adds one cycle, and each packet adds one cycle. The token returns L+NUM_REG+K cycles after a launch at L, where K is the number of packets served, and a new launch, if any, follows one cycle later. The bench counts the edges after each stimulus, computes from these sums the cycle in which every acknowledge, bus word and launch is due, and samples on the falling edge of that cycle. Its packet sources take each packet off the queue on the edge that sees the acknowledge.

// File: rtl/col_arb_pkg.sv
package col_arb_pkg;

    typedef enum logic [1:0] {
        ARB_IDLE   = 2'd0,
        ARB_SERVE  = 2'd1,
        ARB_ACTIVE = 2'd2
    } arb_state_e;

    typedef struct packed {
        arb_state_e state;
    } ctrl_reg_t;

    typedef struct packed {
        logic hold;
    } stage_reg_t;

endpackage

// File: rtl/col_arb_ctrl.sv
module col_arb_ctrl
    import col_arb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_any,
    input  logic tok_return,
    output logic tok_launch
);

    ctrl_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        case (r_q.state)
            ARB_IDLE:   if (req_any) r_d.state = ARB_SERVE;
            ARB_SERVE:  r_d.state = ARB_ACTIVE;
            ARB_ACTIVE: if (tok_return) r_d.state = req_any ? ARB_SERVE : ARB_IDLE;
            default:    r_d.state = ARB_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '{state: ARB_IDLE};
        else        r_q <= r_d;
    end

    assign tok_launch = (r_q.state == ARB_SERVE);

endmodule

// File: rtl/col_region_stage.sv
module col_region_stage
    import col_arb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tok_in,
    input  logic req,
    output logic tok_out,
    output logic grant
);

    stage_reg_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.hold = (r_q.hold & req) | tok_in;
        grant    = r_q.hold & req;
        tok_out  = r_q.hold & ~req;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '{hold: 1'b0};
        else        r_q <= r_d;
    end

endmodule

// File: rtl/col_bus_merge.sv
module col_bus_merge #(
    parameter int NUM_REG = 4,
    parameter int DATA_W  = 8
) (
    input  logic [NUM_REG-1:0]        grant,
    input  logic [NUM_REG*DATA_W-1:0] data_in,
    output logic                      valid,
    output logic [DATA_W-1:0]         data_out
);

    always_comb begin
        valid    = 1'b0;
        data_out = '0;
        for (int i = 0; i < NUM_REG; i++) begin
            if (grant[i]) begin
                valid    = 1'b1;
                data_out = data_out | data_in[i*DATA_W +: DATA_W];
            end
        end
    end

endmodule

// File: rtl/col_token_arbiter.sv
module col_token_arbiter #(
    parameter int NUM_REG = 4,
    parameter int DATA_W  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_REG-1:0]        reg_req,
    input  logic [NUM_REG*DATA_W-1:0] reg_data,
    output logic [NUM_REG-1:0]        reg_ack,
    output logic                      bus_valid,
    output logic [DATA_W-1:0]         bus_data,
    output logic                      token_launch
);

    localparam int CHAIN_LEN = NUM_REG + 1;

    logic [CHAIN_LEN-1:0] tok_chain;
    logic                 req_any;

    assign req_any      = |reg_req;
    assign tok_chain[0] = token_launch;

    col_arb_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_any    (req_any),
        .tok_return (tok_chain[NUM_REG]),
        .tok_launch (token_launch)
    );

    for (genvar g = 0; g < NUM_REG; g++) begin : g_region
        col_region_stage u_stage (
            .clk     (clk),
            .rst_n   (rst_n),
            .tok_in  (tok_chain[g]),
            .req     (reg_req[g]),
            .tok_out (tok_chain[g+1]),
            .grant   (reg_ack[g])
        );
    end

    col_bus_merge #(
        .NUM_REG (NUM_REG),
        .DATA_W  (DATA_W)
    ) u_merge (
        .grant    (reg_ack),
        .data_in  (reg_data),
        .valid    (bus_valid),
        .data_out (bus_data)
    );

endmodule

// File: rtl/col_arb_checker.sv
module col_arb_checker #(
    parameter int NUM_REG = 4,
    parameter int DATA_W  = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_REG-1:0] reg_req,
    input logic [NUM_REG-1:0] reg_ack,
    input logic               bus_valid,
    input logic [DATA_W-1:0]  bus_data,
    input logic               token_launch,
    input logic               tok_return
);

    logic in_flight_q;

    always_ff @(posedge clk) begin
        if (!rst_n)            in_flight_q <= 1'b0;
        else if (token_launch) in_flight_q <= 1'b1;
        else if (tok_return)   in_flight_q <= 1'b0;
    end

    AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(reg_ack)); // R6
    AST_VALID_TRACKS_ACK: assert property (@(posedge clk) disable iff (!rst_n) bus_valid == (|reg_ack)); // R6
    AST_LAUNCH_PULSE: assert property (@(posedge clk) disable iff (!rst_n) token_launch |=> !token_launch); // R3
    AST_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_n) !bus_valid |-> bus_data == '0); // R9
    AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n) (reg_ack & ~reg_req) == '0); // R5
    AST_NO_RELAUNCH: assert property (@(posedge clk) disable iff (!rst_n) token_launch |-> !in_flight_q); // R8
    AST_RETURN_AFTER_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n) tok_return |-> in_flight_q); // R4
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_flight_q && !token_launch && reg_req == '0) |=> !token_launch); // R2

endmodule

bind col_token_arbiter col_arb_checker #(
    .NUM_REG (NUM_REG),
    .DATA_W  (DATA_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_req      (reg_req),
    .reg_ack      (reg_ack),
    .bus_valid    (bus_valid),
    .bus_data     (bus_data),
    .token_launch (token_launch),
    .tok_return   (tok_chain[NUM_REG])
);

// File: tb/col_token_arbiter_test.sv
`timescale 1ns/1ps
module col_token_arbiter_test;

    localparam int N = 4;
    localparam int W = 8;

    typedef int kv_t [N];

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   reg_req;
    logic [N*W-1:0] reg_data;
    logic [N-1:0]   reg_ack;
    logic           bus_valid;
    logic [W-1:0]   bus_data;
    logic           token_launch;

    logic [3:0]     cnt [N];
    logic [3:0]     ld_val [N];
    logic [N-1:0]   ld_mask = '0;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    col_token_arbiter #(.NUM_REG(N), .DATA_W(W)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_req      (reg_req),
        .reg_data     (reg_data),
        .reg_ack      (reg_ack),
        .bus_valid    (bus_valid),
        .bus_data     (bus_data),
        .token_launch (token_launch)
    );

    // packet sources: a packet leaves the queue on the edge that sees its ack
    always @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (!rst_n)               cnt[i] <= '0;
            else if (ld_mask[i])      cnt[i] <= ld_val[i];
            else if (reg_ack[i])      cnt[i] <= cnt[i] - 4'd1;
        end
    end

    always_comb begin
        for (int i = 0; i < N; i++) begin
            reg_req[i]          = (cnt[i] != 4'd0);
            reg_data[i*W +: W]  = {4'(i), cnt[i]};
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // expected ack vector and bus word for a pass launched in cycle L
    function automatic void expect_pass(input int c, input int L, input kv_t k,
                                        output logic [N-1:0] ack, output logic [W-1:0] dat);
        int s;
        ack = '0;
        dat = '0;
        s = L + 1;
        for (int i = 0; i < N; i++) begin
            if (c >= s && c < s + k[i]) begin
                ack[i] = 1'b1;
                dat    = {4'(i), 4'(k[i] - (c - s))};
            end
            s = s + k[i] + 1;
        end
    endfunction

    function automatic int ksum(input kv_t k);
        int t = 0;
        for (int i = 0; i < N; i++) t += k[i];
        return t;
    endfunction

    // k: initial load; mc/mreg/mval: one later load; ka: packets of pass 1; kb: pass 2 (if has2)
    task automatic run_case(input kv_t k, input int mc, input int mreg, input int mval,
                            input kv_t ka, input bit has2, input kv_t kb);
        int l1, r1, l2, r2, last;
        bit p1;
        logic [N-1:0] ea, eb;
        logic [W-1:0] da, db;
        p1   = ksum(ka) > 0;
        l1   = 2;
        r1   = l1 + N + ksum(ka);
        l2   = r1 + 1;
        r2   = l2 + N + ksum(kb);
        last = p1 ? ((has2 ? r2 : r1) + 3) : 6;
        @(negedge clk);
        for (int i = 0; i < N; i++) ld_val[i] = 4'(k[i]);
        ld_mask = '1;
        for (int c = 1; c <= last; c++) begin
            @(negedge clk);
            ea = '0; da = '0; eb = '0; db = '0;
            if (p1) expect_pass(c, l1, ka, ea, da);
            if (has2) expect_pass(c, l2, kb, eb, db);
            chk(token_launch == ((p1 && c == l1) || (has2 && c == l2)),
                "R2 R3 R7 R8 launch", 32'(token_launch), 32'((p1 && c == l1) || (has2 && c == l2)));
            chk(reg_ack == (ea | eb), "R4 R10 ack", 32'(reg_ack), 32'(ea | eb));
            chk(bus_valid == |(ea | eb), "R6 valid", 32'(bus_valid), 32'(|(ea | eb)));
            chk(bus_data == (da | db), "R5 R9 data", 32'(bus_data), 32'(da | db));
            ld_mask = '0;
            if (c == mc) begin
                ld_val[mreg] = 4'(mval);
                ld_mask      = N'(1) << mreg;
            end
        end
    endtask

    initial begin
        kv_t k, z;
        for (int i = 0; i < N; i++) begin
            ld_val[i] = '0;
            z[i]      = 0;
        end
        repeat (3) @(negedge clk);
        // R1: outputs quiet during reset
        chk(!token_launch && !bus_valid && reg_ack == '0 && bus_data == '0, "R1 in reset",
            {bus_data, 4'(reg_ack), 2'b0, bus_valid, token_launch}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!token_launch && !bus_valid && reg_ack == '0 && bus_data == '0, "R1 after reset",
            {bus_data, 4'(reg_ack), 2'b0, bus_valid, token_launch}, 32'd0);

        // sweep every packet count 0..2 per region (all-zero case covers R2)
        for (int v = 0; v < 81; v++) begin
            int t = v;
            for (int i = 0; i < N; i++) begin
                k[i] = t % 3;
                t    = t / 3;
            end
            run_case(k, 0, 0, 0, k, 1'b0, z);
        end

        // R7: region 0 refills after the token left it -> second pass
        k = '{1, 0, 0, 2};
        begin
            kv_t kb2;
            kb2 = '{1, 0, 0, 0};
            run_case(k, 5, 0, 1, k, 1'b1, kb2);
        end

        // R8: region 3 requests while the token is still upstream -> same pass
        k = '{0, 2, 0, 0};
        begin
            kv_t ka2;
            ka2 = '{0, 2, 0, 1};
            run_case(k, 3, 3, 1, ka2, 1'b0, z);
        end

        // R7: many packets in the last region, refill region 2 mid-pass
        k = '{0, 0, 0, 3};
        begin
            kv_t kb3;
            kb3 = '{0, 0, 2, 0};
            run_case(k, 8, 2, 2, k, 1'b1, kb3);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule